// File: doc/BRIEF.md
# Memory access ordering queue

This block sits between one processor and shared memory and holds a small window of pending memory accesses. Accesses arrive in program order on a valid/ready enqueue port, each tagged with one of five kinds (instruction fetch, data read, data write, full barrier, instruction-stream barrier), a physical address and, for writes, data. Each cycle the block offers at most one pending access on a valid/ready issue port toward memory. It may send a younger access ahead of an older one, but only when no pending older access is one it must stay behind under a per-quadword partial order.

Two memory-side hold levels let memory pause the instruction side (fetches) or the data side (reads, writes and both barrier kinds) separately. While one side is held, accesses on the other side that are free of ordering constraints proceed around the held ones. A write cannot wait forever: once it has been pending long enough it takes priority over older eligible entries, as long as the ordering rules still allow it to go.

Top module: `mem_order_queue`

## Requirements
- R1: Kind codes on enq_kind and iss_kind are 0 fetch, 1 read, 2 write, 3 full barrier, 4 instruction barrier. The kind is issued unchanged. iss_addr is zero for barriers. iss_data carries the stored data for writes and is zero for every other kind.
- R2: After reset the queue is empty, iss_valid is 0 and enq_ready is 1.
- R3: Two read/write accesses whose addresses agree above bit 2 leave in enqueue order when at least one is a write (except the case in R5). Address bits [2:0] take no part in this comparison. Two reads, or a fetch and a read, to the same quadword are not ordered.
- R4: Read/write accesses to different quadwords are not ordered with each other. A younger one may issue while an older one is held or blocked.
- R5: A fetch younger than a write to the same quadword may issue before that write, unless an instruction barrier lies between them.
- R6: A full barrier issues only after every older read and write has issued. No younger read, write or barrier issues before it. Fetches on either side of it are not held.
- R7: An instruction barrier orders every older access of any kind against every younger access of any kind.
- R8: While hold_fetch is 1 no fetch is issued. While hold_data is 1 no read, write or barrier is issued.
- R9: The queue holds DEPTH entries. enq_ready is 0 exactly when all are occupied, and an offer made while full is not taken.
- R10: iss_valid is 1 whenever some pending entry is eligible (not held, no older pending entry it must follow). The offered entry is the oldest eligible one unless R11 applies.
- R11: An eligible write that has been pending for at least WAIT_LIMIT cycles is urgent. When any urgent write exists, the oldest urgent write is offered instead.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue offer |
| enq_ready | output | 1 | Queue has a free entry |
| enq_kind | input | 3 | Access kind code (R1) |
| enq_addr | input | AW | Physical byte address |
| enq_data | input | DW | Write data |
| hold_fetch | input | 1 | Memory pauses the instruction side |
| hold_data | input | 1 | Memory pauses the data side |
| iss_valid | output | 1 | An access is offered to memory |
| iss_ready | input | 1 | Memory takes the offered access |
| iss_kind | output | 3 | Kind of offered access |
| iss_addr | output | AW | Address of offered access (zero for barriers) |
| iss_data | output | DW | Write data of offered access (zero unless write) |

## Verification
The bench builds the queue with DEPTH 8, a 16-bit address, 32-bit data and WAIT_LIMIT 16. The short wait limit lets write urgency fire after a stall of under twenty cycles, so urgent writes can be seen jumping ahead of older entries, or being refused that jump by a barrier or a same-quadword conflict. Random addresses come from a pool of four, two of which share a quadword, so that conflicts that depend on bits [2:0] being ignored occur often, and short memory stalls let the queue reach its full depth.

// File: rtl/mo_pkg.sv
package mo_pkg;

  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_READ  = 3'd1,
    K_WRITE = 3'd2,
    K_MB    = 3'd3,
    K_IMB   = 3'd4
  } kind_e;

  // Kinds that go over the data side of memory (everything but fetches).
  function automatic logic data_side(input kind_e k);
    return k != K_FETCH;
  endfunction

  function automatic logic is_barrier(input kind_e k);
    return (k == K_MB) || (k == K_IMB);
  endfunction

  // 1 when a younger access of kind yk must stay behind an older access of
  // kind ok; same_q tells whether the two addresses share a quadword.
  function automatic logic must_follow(input kind_e ok, input kind_e yk,
                                       input logic same_q);
    if (ok == K_IMB || yk == K_IMB) return 1'b1;
    if (ok == K_MB)  return yk != K_FETCH;
    if (yk == K_MB)  return ok != K_FETCH;
    if (!same_q)     return 1'b0;
    if (ok == K_WRITE && yk == K_FETCH) return 1'b0;
    return (ok == K_WRITE) || (yk == K_WRITE);
  endfunction

endpackage

// File: rtl/mo_slots.sv
// Collapsing entry store: slot 0 is always the oldest pending entry.
module mo_slots
  import mo_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int AW         = 32,
  parameter int DW         = 64,
  parameter int WAIT_LIMIT = 64,
  localparam int IW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int CW   = $clog2(WAIT_LIMIT + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  kind_e                      push_kind,
  input  logic [AW-1:0]              push_addr,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  input  logic [IW-1:0]              pop_idx,
  output logic [CNTW-1:0]            count,
  output logic [DEPTH-1:0]           vld,
  output kind_e [DEPTH-1:0]          kinds,
  output logic [DEPTH-1:0][AW-1:0]   addrs,
  output logic [DEPTH-1:0][DW-1:0]   datas,
  output logic [DEPTH-1:0][CW-1:0]   waits
);

  logic [CNTW-1:0]          count_q, count_d, keep_cnt;
  kind_e [DEPTH-1:0]        kind_q, kind_d;
  logic [DEPTH-1:0][AW-1:0] addr_q, addr_d;
  logic [DEPTH-1:0][DW-1:0] data_q, data_d;
  logic [DEPTH-1:0][CW-1:0] wait_q, wait_d;

  function automatic logic [CW-1:0] wait_step(input logic [CW-1:0] w);
    return (w == CW'(WAIT_LIMIT)) ? w : w + 1'b1;
  endfunction

  assign keep_cnt = count_q - CNTW'(pop);
  assign count_d  = keep_cnt + CNTW'(push);

  always_comb begin
    kind_d = kind_q;
    addr_d = addr_q;
    data_d = data_q;
    wait_d = wait_q;
    for (int i = 0; i < DEPTH; i++) begin
      int src;
      src = (pop && i >= int'(pop_idx)) ? i + 1 : i;
      if (i < int'(keep_cnt)) begin
        kind_d[i] = kind_q[src];
        addr_d[i] = addr_q[src];
        data_d[i] = data_q[src];
        wait_d[i] = wait_step(wait_q[src]);
      end else if (push && i == int'(keep_cnt)) begin
        kind_d[i] = push_kind;
        addr_d[i] = push_addr;
        data_d[i] = push_data;
        wait_d[i] = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      kind_q  <= {DEPTH{K_FETCH}};
      addr_q  <= '0;
      data_q  <= '0;
      wait_q  <= '0;
    end else begin
      count_q <= count_d;
      kind_q  <= kind_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      wait_q  <= wait_d;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_vld
      assign vld[g] = CNTW'(g) < count_q;
    end
  endgenerate

  assign count = count_q;
  assign kinds = kind_q;
  assign addrs = addr_q;
  assign datas = data_q;
  assign waits = wait_q;

endmodule

// File: rtl/mo_order_matrix.sv
// Pairwise ordering check: an entry is blocked by any older pending entry it
// must follow, and held when memory pauses its side.
module mo_order_matrix
  import mo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int QW    = 29
) (
  input  logic [DEPTH-1:0]         vld,
  input  kind_e [DEPTH-1:0]        kinds,
  input  logic [DEPTH-1:0][QW-1:0] quads,
  input  logic                     hold_fetch,
  input  logic                     hold_data,
  output logic [DEPTH-1:0]         blocked,
  output logic [DEPTH-1:0]         held,
  output logic [DEPTH-1:0]         elig
);

  generate
    for (genvar j = 0; j < DEPTH; j++) begin : g_young
      logic [DEPTH-1:0] dep;
      for (genvar i = 0; i < DEPTH; i++) begin : g_old
        if (i < j) begin : g_pair
          assign dep[i] = vld[i] &&
                          must_follow(kinds[i], kinds[j], quads[i] == quads[j]);
        end else begin : g_none
          assign dep[i] = 1'b0;
        end
      end
      assign blocked[j] = |dep;
      assign held[j]    = data_side(kinds[j]) ? hold_data : hold_fetch;
      assign elig[j]    = vld[j] && !blocked[j] && !held[j];
    end
  endgenerate

endmodule

// File: rtl/mo_pick.sv
// Selects the entry to offer: oldest urgent write, else oldest eligible.
module mo_pick
  import mo_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int WAIT_LIMIT = 64,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(WAIT_LIMIT + 1)
) (
  input  logic [DEPTH-1:0]         elig,
  input  kind_e [DEPTH-1:0]        kinds,
  input  logic [DEPTH-1:0][CW-1:0] waits,
  output logic [DEPTH-1:0]         urgent,
  output logic [DEPTH-1:0]         pick_vec,
  output logic [IW-1:0]            pick_idx,
  output logic                     any
);

  logic [DEPTH-1:0] pool;

  function automatic logic [DEPTH-1:0] lowest_one(input logic [DEPTH-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  function automatic logic [IW-1:0] index_of(input logic [DEPTH-1:0] oh);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (oh[i]) r = IW'(i);
    end
    return r;
  endfunction

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_urg
      assign urgent[g] = elig[g] && (kinds[g] == K_WRITE) &&
                         (waits[g] >= CW'(WAIT_LIMIT));
    end
  endgenerate

  assign pool     = (|urgent) ? urgent : elig;
  assign pick_vec = lowest_one(pool);
  assign pick_idx = index_of(pick_vec);
  assign any      = |elig;

endmodule

// File: rtl/mem_order_queue.sv
module mem_order_queue
  import mo_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int AW         = 32,
  parameter int DW         = 64,
  parameter int WAIT_LIMIT = 64,
  localparam int IW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int CW   = $clog2(WAIT_LIMIT + 1),
  localparam int QW   = AW - 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_valid,
  output logic          enq_ready,
  input  logic [2:0]    enq_kind,
  input  logic [AW-1:0] enq_addr,
  input  logic [DW-1:0] enq_data,
  input  logic          hold_fetch,
  input  logic          hold_data,
  output logic          iss_valid,
  input  logic          iss_ready,
  output logic [2:0]    iss_kind,
  output logic [AW-1:0] iss_addr,
  output logic [DW-1:0] iss_data
);

  // Named internal events, visible to the bound checker.
  logic                     push_fire, pop_fire;
  logic [CNTW-1:0]          count;
  logic [DEPTH-1:0]         vld, blocked, held, elig, urgent, pick_vec;
  logic [IW-1:0]            pick_idx;
  logic                     any_elig;
  kind_e [DEPTH-1:0]        kinds;
  logic [DEPTH-1:0][AW-1:0] addrs;
  logic [DEPTH-1:0][DW-1:0] datas;
  logic [DEPTH-1:0][CW-1:0] waits;
  logic [DEPTH-1:0][QW-1:0] quads;
  kind_e                    sel_kind;

  assign enq_ready = count < CNTW'(DEPTH);
  assign push_fire = enq_valid && enq_ready;
  assign pop_fire  = iss_valid && iss_ready;

  mo_slots #(
    .DEPTH(DEPTH), .AW(AW), .DW(DW), .WAIT_LIMIT(WAIT_LIMIT)
  ) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_fire),
    .push_kind (kind_e'(enq_kind)),
    .push_addr (enq_addr),
    .push_data (enq_data),
    .pop       (pop_fire),
    .pop_idx   (pick_idx),
    .count     (count),
    .vld       (vld),
    .kinds     (kinds),
    .addrs     (addrs),
    .datas     (datas),
    .waits     (waits)
  );

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_quad
      assign quads[g] = addrs[g][AW-1:3];
    end
  endgenerate

  mo_order_matrix #(.DEPTH(DEPTH), .QW(QW)) u_matrix (
    .vld        (vld),
    .kinds      (kinds),
    .quads      (quads),
    .hold_fetch (hold_fetch),
    .hold_data  (hold_data),
    .blocked    (blocked),
    .held       (held),
    .elig       (elig)
  );

  mo_pick #(.DEPTH(DEPTH), .WAIT_LIMIT(WAIT_LIMIT)) u_pick (
    .elig     (elig),
    .kinds    (kinds),
    .waits    (waits),
    .urgent   (urgent),
    .pick_vec (pick_vec),
    .pick_idx (pick_idx),
    .any      (any_elig)
  );

  assign sel_kind  = kinds[pick_idx];
  assign iss_valid = any_elig;
  assign iss_kind  = sel_kind;
  assign iss_addr  = is_barrier(sel_kind) ? '0 : addrs[pick_idx];
  assign iss_data  = (sel_kind == K_WRITE) ? datas[pick_idx] : '0;

endmodule

// File: rtl/mo_checker.sv
module mo_checker
  import mo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 64,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enq_ready,
  input logic            hold_fetch,
  input logic            hold_data,
  input logic            iss_valid,
  input logic [2:0]      iss_kind,
  input logic [AW-1:0]   iss_addr,
  input logic [DW-1:0]   iss_data,
  input logic            push_fire,
  input logic            pop_fire,
  input logic [CNTW-1:0] count,
  input logic [DEPTH-1:0] urgent,
  input logic [DEPTH-1:0] pick_vec
);

  a_r2_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!iss_valid && enq_ready));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (count <= CNTW'(DEPTH)) && ((count == CNTW'(DEPTH)) == !enq_ready));

  a_r9_count_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> count == $past(count) + CNTW'($past(push_fire))
                                            - CNTW'($past(pop_fire)));

  a_r10_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_vec) && (iss_valid == (|pick_vec)));

  a_r8_holds_respected: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !(hold_fetch && iss_kind == 3'd0) &&
                  !(hold_data && iss_kind != 3'd0));

  a_r1_barrier_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && (iss_kind == 3'd3 || iss_kind == 3'd4)) |->
      (iss_addr == '0 && iss_data == '0));

  a_r11_urgent_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|urgent) |-> (iss_valid && iss_kind == 3'd2));

endmodule

bind mem_order_queue mo_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enq_ready  (enq_ready),
  .hold_fetch (hold_fetch),
  .hold_data  (hold_data),
  .iss_valid  (iss_valid),
  .iss_kind   (iss_kind),
  .iss_addr   (iss_addr),
  .iss_data   (iss_data),
  .push_fire  (push_fire),
  .pop_fire   (pop_fire),
  .count      (count),
  .urgent     (urgent),
  .pick_vec   (pick_vec)
);

// File: tb/sim_mem_order_queue.sv
module sim_mem_order_queue;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LIMIT = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enq_valid = 1'b0;
  logic          enq_ready;
  logic [2:0]    enq_kind = 3'd0;
  logic [AW-1:0] enq_addr = '0;
  logic [DW-1:0] enq_data = '0;
  logic          hold_fetch = 1'b0;
  logic          hold_data = 1'b0;
  logic          iss_valid;
  logic          iss_ready = 1'b0;
  logic [2:0]    iss_kind;
  logic [AW-1:0] iss_addr;
  logic [DW-1:0] iss_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mem_order_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .WAIT_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_kind(enq_kind),
    .enq_addr(enq_addr), .enq_data(enq_data),
    .hold_fetch(hold_fetch), .hold_data(hold_data),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_kind(iss_kind),
    .iss_addr(iss_addr), .iss_data(iss_data)
  );

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference queue, oldest at index 0.
  int          mcnt = 0;
  int          mk [DEPTH];
  logic [AW-1:0] ma [DEPTH];
  logic [DW-1:0] md [DEPTH];
  int          mw [DEPTH];

  bit          got_fire;
  logic [2:0]  got_k;
  logic [AW-1:0] got_a;
  logic [DW-1:0] got_d;
  int          fired_total = 0;

  task automatic check(input bit ok, input string tag, input longint act,
                       input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Does younger (yk,ya) have to wait for older (ok,oa)?
  function automatic bit stays_behind(int ok, logic [AW-1:0] oa, int yk,
                                      logic [AW-1:0] ya);
    bit same;
    same = (oa >> 3) == (ya >> 3);
    if (ok == 4 || yk == 4) return 1;
    if (ok == 3 || yk == 3) return (ok != 0) && (yk != 0);
    if (ok == 2 && yk == 0) return 0;
    return same && (ok == 2 || yk == 2);
  endfunction

  function automatic bit may_go(int j, bit hf, bit hd);
    if (mk[j] == 0 ? hf : hd) return 0;
    for (int i = 0; i < j; i++)
      if (stays_behind(mk[i], ma[i], mk[j], ma[j])) return 0;
    return 1;
  endfunction

  function automatic int model_pick(bit hf, bit hd);
    int first;
    first = -1;
    for (int j = 0; j < mcnt; j++)
      if (may_go(j, hf, hd) && mk[j] == 2 && mw[j] >= LIMIT) return j;
    for (int j = 0; j < mcnt; j++)
      if (may_go(j, hf, hd)) begin first = j; break; end
    return first;
  endfunction

  // One clock: drive, compare against the model, advance the model.
  task automatic cycle(input bit ev, input int k, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input bit rdy, input bit hf,
                       input bit hd);
    int  p;
    bit  take;
    enq_valid = ev; enq_kind = 3'(k); enq_addr = a; enq_data = d;
    iss_ready = rdy; hold_fetch = hf; hold_data = hd;
    #1;
    p = model_pick(hf, hd);
    check(enq_ready == (mcnt < DEPTH), "R9 enq_ready", enq_ready, mcnt < DEPTH);
    check(iss_valid == (p >= 0), "R10 iss_valid", iss_valid, p >= 0);
    if (p >= 0 && iss_valid) begin
      logic [AW-1:0] ea;
      logic [DW-1:0] ed;
      ea = (mk[p] >= 3) ? '0 : ma[p];
      ed = (mk[p] == 2) ? md[p] : '0;
      check(iss_kind == 3'(mk[p]) && iss_addr == ea && iss_data == ed,
            "R10/R11 offered entry", {iss_kind, iss_addr, iss_data},
            {3'(mk[p]), ea, ed});
    end
    got_fire = iss_valid && rdy;
    got_k = iss_kind; got_a = iss_addr; got_d = iss_data;
    if (got_fire) fired_total++;
    take = ev && (mcnt < DEPTH);
    if (p >= 0 && rdy) begin
      for (int i = p; i < mcnt - 1; i++) begin
        mk[i] = mk[i+1]; ma[i] = ma[i+1]; md[i] = md[i+1]; mw[i] = mw[i+1];
      end
      mcnt--;
    end
    for (int i = 0; i < mcnt; i++) if (mw[i] < LIMIT) mw[i]++;
    if (take) begin
      mk[mcnt] = k; ma[mcnt] = a; md[mcnt] = d; mw[mcnt] = 0; mcnt++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input int k, input logic [AW-1:0] a, input logic [DW-1:0] d);
    cycle(1, k, a, d, 0, 0, 0);
  endtask

  task automatic idle(input int n, input bit rdy, input bit hf, input bit hd);
    for (int i = 0; i < n; i++) cycle(0, 0, '0, '0, rdy, hf, hd);
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && mcnt > 0; i++) cycle(0, 0, '0, '0, 1, 0, 0);
    check(mcnt == 0 && !iss_valid, "R10 drained", iss_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed_sink;
    int stall;
    seed_sink = $urandom(32'd1931);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!iss_valid && enq_ready, "R2 reset state", {iss_valid, enq_ready}, 2'b01);
    @(negedge clk);

    // R3: write to 0x104 shares a quadword with the older read of 0x100.
    put(1, 16'h0100, 0); put(2, 16'h0104, 32'hA1);
    idle(LIMIT + 1, 0, 0, 0);
    idle(1, 1, 0, 0);
    check(got_fire && got_k == 1 && got_a == 16'h0100, "R3 urgent write held by same quad",
          got_a, 16'h0100);
    drain();

    // R4: different quadword, urgent write overtakes the older read.
    put(1, 16'h0100, 0); put(2, 16'h0208, 32'hB2);
    idle(LIMIT + 1, 0, 0, 0);
    idle(1, 1, 0, 0);
    check(got_fire && got_k == 2 && got_d == 32'hB2, "R4 write passes other quad",
          got_d, 32'hB2);
    drain();

    // R5: fetch passes the write to its own quadword.
    put(2, 16'h0300, 32'hC3); put(0, 16'h0301, 0);
    idle(1, 1, 0, 1);
    check(got_fire && got_k == 0 && got_a == 16'h0301, "R5 fetch passes write",
          got_k, 0);
    drain();

    // R7: instruction barrier in between stops the fetch; R8 data side held.
    put(2, 16'h0300, 32'hC4); put(4, 16'h0000, 0); put(0, 16'h0300, 0);
    idle(2, 1, 0, 1);
    check(!got_fire && !iss_valid, "R7 fetch fenced by instruction barrier",
          iss_valid, 0);
    idle(1, 1, 1, 0);
    check(got_fire && got_k == 2, "R8 fetch hold leaves data side", got_k, 2);
    drain();

    // R6: full barrier does not hold a fetch but holds a younger write.
    put(1, 16'h0500, 0); put(3, 16'h0000, 0); put(2, 16'h0600, 32'hD4);
    put(0, 16'h0400, 0);
    idle(1, 1, 0, 1);
    check(got_fire && got_k == 0 && got_a == 16'h0400, "R6 fetch passes barrier",
          got_a, 16'h0400);
    idle(LIMIT + 1, 0, 0, 0);
    idle(1, 1, 0, 0);
    check(got_fire && got_k == 1 && got_a == 16'h0500, "R6 urgent write stays behind barrier",
          got_a, 16'h0500);
    idle(1, 1, 0, 0);
    check(got_fire && got_k == 3 && got_a == 0 && got_d == 0, "R1 barrier code and zero fields",
          got_k, 3);
    idle(1, 1, 0, 0);
    check(got_fire && got_k == 2 && got_d == 32'hD4, "R6 write after barrier", got_d, 32'hD4);
    drain();

    // Litmus pattern: write x, barrier, write y, read y, read x.
    put(2, 16'h0800, 32'hE1); put(3, 0, 0); put(2, 16'h0900, 32'hE2);
    put(1, 16'h0900, 0); put(1, 16'h0800, 0);
    idle(LIMIT + 1, 0, 0, 0);
    idle(1, 1, 0, 0);
    check(got_fire && got_d == 32'hE1, "R6 litmus write x first", got_d, 32'hE1);
    idle(1, 1, 0, 0);
    check(got_fire && got_k == 3, "R6 litmus barrier second", got_k, 3);
    idle(1, 1, 0, 0);
    check(got_fire && got_d == 32'hE2, "R6 litmus write y third", got_d, 32'hE2);
    drain();

    // R9: offer ten entries with memory stalled; only DEPTH are taken.
    fired_total = 0;
    for (int i = 0; i < 10; i++) put(1, 16'(16'h0A00 + 8 * i), 0);
    check(!enq_ready, "R9 full queue refuses", enq_ready, 0);
    drain();
    check(fired_total == DEPTH, "R9 only DEPTH entries kept", fired_total, DEPTH);

    // Random phase.
    stall = 0;
    for (int c = 0; c < 4000; c++) begin
      int  r, k;
      bit  ev, rdy;
      logic [AW-1:0] a;
      r = $urandom_range(99);
      k = (r < 20) ? 0 : (r < 50) ? 1 : (r < 80) ? 2 : (r < 90) ? 3 : 4;
      case ($urandom_range(3))
        0: a = 16'h0100;
        1: a = 16'h0104;
        2: a = 16'h0108;
        default: a = 16'h0200;
      endcase
      ev = $urandom_range(99) < 55;
      if (stall == 0 && $urandom_range(99) < 3) stall = LIMIT + 4;
      rdy = (stall == 0) && ($urandom_range(99) < 70);
      if (stall > 0) stall--;
      cycle(ev, k, a, DW'($urandom), rdy, $urandom_range(99) < 20,
            $urandom_range(99) < 20);
    end
    drain();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule